// File: doc/BRIEF.md
# Buffered Block-Transfer Byte Store

This block sits between the register interface of a two-wire host controller and its transaction engine. It holds up to 32 payload bytes for block reads and block writes. Software reaches the bytes through one register, and an index that advances after every access walks that register across the store. Before it starts a block write, software reads the control register to rewind the index and writes the payload one byte at a time. It then writes the byte count into the count register. After a block read, software rewinds the index the same way, reads the count that the target returned, and drains that many bytes.

The transaction engine has a port of its own with a separate pointer. A transaction start rewinds that pointer. During a write the engine pulls bytes in order. During a read it delivers the target's count and then pushes the received bytes. A received count that is zero or larger than the store is remembered and reported as a protocol error once the transaction completes. Buffered mode exists only while the mode bit of the auxiliary register is set. While that bit is clear, the store ignores both ports.

Top module: `blkbuf_host`

## Requirements
- R1: After reset the index and the engine pointer are 0, every stored byte and the count, control and auxiliary registers read 0x00, buffered mode is off and the protocol error output is low.
- R2: With buffered mode on, a write to the block register (address 2) stores the byte at the current index, and the index advances by one.
- R3: With buffered mode on, a read of the block register returns the byte at the current index in the same cycle, and the index advances by one.
- R4: Any read of the control register (address 0) returns its stored value and sets the index to 0. A write to the control register is stored and leaves the index unchanged.
- R5: The index stops at 32. Once it is there, block-register writes are dropped and block-register reads return 0x00.
- R6: Bit 1 of the auxiliary register (address 3) is the buffered-mode enable and reads back as written, with every other bit reading 0. While it is clear, block-register accesses change neither the store nor the index, block reads return 0x00, and engine strobes are ignored.
- R7: The count register (address 1) holds the value software writes and drives the engine length output. After an engine start, each take strobe steps the engine byte output through the store from position 0.
- R8: An engine count strobe loads the received count into the count register, which software can read. Engine put strobes store bytes from position 0 upward, and software can read them back after rewinding the index.
- R9: If the received count is 0 or above 32, the protocol error output rises in the cycle after the engine done strobe and stays high until the next engine start. A legal count leaves it low.
- R10: The engine pointer stops at 32. Puts beyond 32 bytes are dropped, and the engine byte output then reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (has side effects) |
| regAddr | input | 2 | Register select: 0 control, 1 count, 2 block, 3 auxiliary |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for the selected register |
| engStart | input | 1 | Engine transaction start |
| engTake | input | 1 | Engine consumes the byte on engRdByte |
| engPut | input | 1 | Engine stores engPutData |
| engPutData | input | 8 | Byte received from the target |
| engCount | input | 1 | Engine delivers the received count |
| engCountData | input | 8 | Received count value |
| engDone | input | 1 | Engine transaction complete |
| engRdByte | output | 8 | Byte at the engine pointer |
| engLen | output | 8 | Current count register value |
| bufMode | output | 1 | Buffered mode is on |
| protoErr | output | 1 | Illegal received count reported |

## Verification
The hardest cases to reach are the two saturated edges. One is a target that announces a count of 40 and then keeps pushing bytes past the end of the store. The other is a software pointer that has run off the end and must return zeros. The stimulus drives the engine port directly with that oversized count and 34 puts, and it also writes and reads 34 bytes through the block register. Each run is followed by an index rewind and a drain, so that the dropped bytes show up at the ports. The reference model tracks the index, the pointer and the store as plain integers and compares every output on every clock. This also covers the mode-off cases, where accesses must have no effect.

// File: rtl/blkbuf_pkg.sv
package blkbuf_pkg;

  // register selects seen by software
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_BLOCK = 2'd2,
    SEL_AUX   = 2'd3
  } regSel_t;

  // position of the buffered-mode enable inside the auxiliary register
  localparam int AUX_MODE_BIT = 1;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic ctrlWr;
    logic countWr;
    logic bufWr;
    logic bufRd;
    logic idxClr;
    logic engStart;
    logic engTake;
    logic engPut;
    logic engCount;
    logic engDone;
  } bufStrobe_t;

endpackage

// File: rtl/blkbuf_ctrl.sv
module blkbuf_ctrl
  import blkbuf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWr,
  input  logic          regRd,
  input  logic [1:0]    regAddr,
  input  logic [DW-1:0] regWdata,
  input  logic          engStartI,
  input  logic          engTakeI,
  input  logic          engPutI,
  input  logic          engCountI,
  input  logic          engDoneI,
  output bufStrobe_t    strobe,
  output logic          modeOn
);

  regSel_t sel;
  logic    wrAcc;
  logic    rdAcc;

  assign sel   = regSel_t'(regAddr);
  assign wrAcc = regWr;
  assign rdAcc = regRd && !regWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeOn <= 1'b0;
    end else if (wrAcc && sel == SEL_AUX) begin
      modeOn <= regWdata[AUX_MODE_BIT];
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.ctrlWr   = wrAcc && sel == SEL_CTRL;
    strobe.countWr  = wrAcc && sel == SEL_COUNT;
    strobe.bufWr    = wrAcc && sel == SEL_BLOCK && modeOn;
    strobe.bufRd    = rdAcc && sel == SEL_BLOCK && modeOn;
    strobe.idxClr   = rdAcc && sel == SEL_CTRL;
    strobe.engStart = engStartI && modeOn;
    strobe.engTake  = engTakeI && modeOn;
    strobe.engPut   = engPutI && modeOn;
    strobe.engCount = engCountI && modeOn;
    strobe.engDone  = engDoneI && modeOn;
  end

  // mode bit follows the last auxiliary write
  assert_mode_readback_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && sel == SEL_AUX) |=> (modeOn == $past(regWdata[AUX_MODE_BIT])));

  // at most one software-side action per cycle
  assert_one_access_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.ctrlWr, strobe.countWr, strobe.bufWr, strobe.bufRd, strobe.idxClr}));

  // no buffer access leaks through while mode is off
  assert_mode_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    !modeOn |-> !(strobe.bufWr || strobe.bufRd || strobe.engPut || strobe.engStart));

endmodule

// File: rtl/blkbuf_dpath.sv
module blkbuf_dpath
  import blkbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  bufStrobe_t    strobe,
  input  logic          modeOn,
  input  logic [1:0]    regAddr,
  input  logic [DW-1:0] regWdata,
  input  logic [DW-1:0] engPutData,
  input  logic [DW-1:0] engCountData,
  output logic [DW-1:0] regRdata,
  output logic [DW-1:0] engRdByte,
  output logic [DW-1:0] engLen,
  output logic          protoErr
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int IW = $clog2(DEPTH + 1);
  localparam logic [IW-1:0] FULL = IW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] idx;
  logic [IW-1:0] engPtr;
  logic [DW-1:0] countReg;
  logic [DW-1:0] ctrlReg;
  logic          badSeen;
  logic          idxAtEnd;
  logic          engAtEnd;
  logic          cntIllegal;
  logic [DW-1:0] bufByte;
  logic [DW-1:0] auxVal;

  assign idxAtEnd   = (idx == FULL);
  assign engAtEnd   = (engPtr == FULL);
  assign cntIllegal = (engCountData == '0) || (int'(engCountData) > DEPTH);

  // software index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx <= '0;
    end else if (strobe.idxClr) begin
      idx <= '0;
    end else if ((strobe.bufWr || strobe.bufRd) && !idxAtEnd) begin
      idx <= idx + 1'b1;
    end
  end

  // engine pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      engPtr <= '0;
    end else if (strobe.engStart) begin
      engPtr <= '0;
    end else if ((strobe.engTake || strobe.engPut) && !engAtEnd) begin
      engPtr <= engPtr + 1'b1;
    end
  end

  // byte store, engine store wins a shared cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (strobe.engPut && !strobe.engStart && !engAtEnd) begin
      mem[engPtr[AW-1:0]] <= engPutData;
    end else if (strobe.bufWr && !idxAtEnd) begin
      mem[idx[AW-1:0]] <= regWdata;
    end
  end

  // count and control registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      countReg <= '0;
      ctrlReg  <= '0;
    end else begin
      if (strobe.engCount)     countReg <= engCountData;
      else if (strobe.countWr) countReg <= regWdata;
      if (strobe.ctrlWr)       ctrlReg  <= regWdata;
    end
  end

  // count validation and completion error
  always_ff @(posedge clk) begin
    if (!rstN) begin
      badSeen  <= 1'b0;
      protoErr <= 1'b0;
    end else if (strobe.engStart) begin
      badSeen  <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      if (strobe.engCount) badSeen <= cntIllegal;
      if (strobe.engDone && badSeen) protoErr <= 1'b1;
    end
  end

  always_comb begin
    bufByte = idxAtEnd ? '0 : mem[idx[AW-1:0]];
    auxVal  = '0;
    auxVal[AUX_MODE_BIT] = modeOn;
    case (regSel_t'(regAddr))
      SEL_CTRL:  regRdata = ctrlReg;
      SEL_COUNT: regRdata = countReg;
      SEL_BLOCK: regRdata = modeOn ? bufByte : '0;
      default:   regRdata = auxVal;
    endcase
  end

  assign engRdByte = engAtEnd ? '0 : mem[engPtr[AW-1:0]];
  assign engLen    = countReg;

  assert_idx_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    (idx <= FULL) && (engPtr <= FULL));

  assert_wr_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bufWr && !idxAtEnd) |=> (idx == $past(idx) + 1'b1));

  assert_rd_advance_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bufRd && !idxAtEnd) |=> (idx == $past(idx) + 1'b1));

  assert_idx_rewind_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.idxClr |=> (idx == '0));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.bufWr || strobe.bufRd) && idxAtEnd) |=> (idx == FULL));

  assert_eng_saturate_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.engPut && !strobe.engStart && engAtEnd) |=> (engPtr == FULL));

  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protoErr) |-> $past(strobe.engDone));

  assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (protoErr && !strobe.engStart) |=> protoErr);

endmodule

// File: rtl/blkbuf_host.sv
module blkbuf_host
  import blkbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWr,
  input  logic          regRd,
  input  logic [1:0]    regAddr,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  input  logic          engStart,
  input  logic          engTake,
  input  logic          engPut,
  input  logic [DW-1:0] engPutData,
  input  logic          engCount,
  input  logic [DW-1:0] engCountData,
  input  logic          engDone,
  output logic [DW-1:0] engRdByte,
  output logic [DW-1:0] engLen,
  output logic          bufMode,
  output logic          protoErr
);

  bufStrobe_t strobe;
  logic       modeOn;

  blkbuf_ctrl #(.DW(DW)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regRd     (regRd),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .engStartI (engStart),
    .engTakeI  (engTake),
    .engPutI   (engPut),
    .engCountI (engCount),
    .engDoneI  (engDone),
    .strobe    (strobe),
    .modeOn    (modeOn)
  );

  blkbuf_dpath #(.DEPTH(DEPTH), .DW(DW)) i_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .modeOn       (modeOn),
    .regAddr      (regAddr),
    .regWdata     (regWdata),
    .engPutData   (engPutData),
    .engCountData (engCountData),
    .regRdata     (regRdata),
    .engRdByte    (engRdByte),
    .engLen       (engLen),
    .protoErr     (protoErr)
  );

  assign bufMode = modeOn;

endmodule

// File: tb/test_blkbuf_host.sv
`timescale 1ns/1ps
module test_blkbuf_host;

  localparam int DEPTH = 32;

  logic       clk = 1'b0;
  logic       rstN;
  logic       regWr, regRd;
  logic [1:0] regAddr;
  logic [7:0] regWdata, regRdata;
  logic       engStart, engTake, engPut, engCount, engDone;
  logic [7:0] engPutData, engCountData, engRdByte, engLen;
  logic       bufMode, protoErr;

  always #4 clk = ~clk;

  blkbuf_host i_blkbuf_host (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .engStart(engStart),
    .engTake(engTake), .engPut(engPut), .engPutData(engPutData),
    .engCount(engCount), .engCountData(engCountData), .engDone(engDone),
    .engRdByte(engRdByte), .engLen(engLen), .bufMode(bufMode), .protoErr(protoErr)
  );

  int    nRun = 0;
  int    nFail = 0;
  string tag = "R1";

  // behavioural reference state
  int mMem[DEPTH];
  int mIdx, mPtr, mData0, mCtrl, mMode, mBad, mErr;

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic int expRd();
    case (regAddr)
      2'd0: return mCtrl;
      2'd1: return mData0;
      2'd2: return (mMode != 0 && mIdx < DEPTH) ? mMem[mIdx] : 0;
      default: return (mMode != 0) ? 2 : 0;
    endcase
  endfunction

  task automatic compareAll();
    check("regRdata", {24'd0, regRdata}, expRd());
    check("engRdByte", {24'd0, engRdByte}, (mPtr < DEPTH) ? mMem[mPtr] : 0);
    check("engLen", {24'd0, engLen}, mData0);
    check("protoErr", {31'd0, protoErr}, mErr);
    check("bufMode", {31'd0, bufMode}, mMode);
  endtask

  task automatic modelEdge();
    int oi = mIdx;
    int op = mPtr;
    int om = mMode;
    int ob = mBad;
    if (regWr) begin
      case (regAddr)
        2'd0: mCtrl = regWdata;
        2'd1: mData0 = regWdata;
        2'd2: if (om != 0 && oi < DEPTH) begin mMem[oi] = regWdata; mIdx = oi + 1; end
        default: mMode = regWdata[1];
      endcase
    end else if (regRd) begin
      if (regAddr == 2'd0) mIdx = 0;
      else if (regAddr == 2'd2 && om != 0 && oi < DEPTH) mIdx = oi + 1;
    end
    if (om != 0) begin
      if (engStart) begin
        mPtr = 0; mBad = 0; mErr = 0;
      end else begin
        if ((engTake || engPut) && op < DEPTH) begin
          if (engPut) mMem[op] = engPutData;
          mPtr = op + 1;
        end
        if (engCount) begin
          mData0 = engCountData;
          mBad = (engCountData == 0 || engCountData > DEPTH) ? 1 : 0;
        end
        if (engDone && ob != 0) mErr = 1;
      end
    end
  endtask

  task automatic clearIn();
    regWr = 0; regRd = 0; regAddr = 0; regWdata = 0;
    engStart = 0; engTake = 0; engPut = 0; engPutData = 0;
    engCount = 0; engCountData = 0; engDone = 0;
  endtask

  task automatic step();
    #1 compareAll();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    clearIn();
  endtask

  task automatic swWr(input logic [1:0] a, input logic [7:0] d);
    regWr = 1; regAddr = a; regWdata = d; step();
  endtask
  task automatic swRd(input logic [1:0] a);
    regRd = 1; regAddr = a; step();
  endtask
  task automatic eStart(); engStart = 1; step(); endtask
  task automatic eTake(); engTake = 1; step(); endtask
  task automatic ePut(input logic [7:0] d); engPut = 1; engPutData = d; step(); endtask
  task automatic eCnt(input logic [7:0] c); engCount = 1; engCountData = c; step(); endtask
  task automatic eDone(); engDone = 1; step(); endtask
  task automatic idle(); step(); endtask

  initial begin
    repeat (100000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    clearIn();
    rstN = 0;
    for (int k = 0; k < DEPTH; k++) mMem[k] = 0;
    mIdx = 0; mPtr = 0; mData0 = 0; mCtrl = 0; mMode = 0; mBad = 0; mErr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    tag = "R1";
    swRd(2'd3); swRd(2'd1); swRd(2'd0); idle();

    tag = "R6";   // mode off: accesses have no effect
    swWr(2'd2, 8'hAA); swRd(2'd2); eStart(); ePut(8'h55); eCnt(8'd0); eDone(); idle();
    swWr(2'd3, 8'hFF); swRd(2'd3);
    swWr(2'd3, 8'h02); swRd(2'd3); swRd(2'd0); swRd(2'd2);

    tag = "R4";
    swWr(2'd0, 8'h5C); swRd(2'd0);
    tag = "R2";
    for (int i = 0; i < 5; i++) swWr(2'd2, 8'(8'h10 + i * 7));
    tag = "R4";
    swWr(2'd0, 8'h33); swRd(2'd2); swRd(2'd0);
    tag = "R3";
    for (int i = 0; i < 6; i++) swRd(2'd2);

    tag = "R5";
    swRd(2'd0);
    for (int i = 0; i < 34; i++) swWr(2'd2, 8'(i * 3 + 1));
    swRd(2'd0);
    for (int i = 0; i < 34; i++) swRd(2'd2);

    tag = "R7";
    swRd(2'd0);
    for (int i = 0; i < 4; i++) swWr(2'd2, 8'(8'hC0 | i));
    swWr(2'd1, 8'd4); swRd(2'd1);
    eStart();
    for (int i = 0; i < 4; i++) eTake();
    eDone(); idle();

    tag = "R8";
    eStart(); eCnt(8'd3);
    ePut(8'h9A); ePut(8'h9B); ePut(8'h9C);
    eDone(); idle(); swRd(2'd1); swRd(2'd0);
    for (int i = 0; i < 3; i++) swRd(2'd2);

    tag = "R9";
    eStart(); eCnt(8'd32); eDone(); idle();
    eStart(); eCnt(8'd0); idle(); eDone(); idle(); idle(); idle();
    eStart(); idle();
    eStart(); eCnt(8'd33); eDone(); idle();

    tag = "R10";
    eStart(); eCnt(8'd40);
    for (int i = 0; i < 34; i++) ePut(8'(8'h40 + i));
    eDone(); idle();
    swRd(2'd0);
    for (int i = 0; i < 33; i++) swRd(2'd2);

    tag = "R6";
    swWr(2'd3, 8'h00); swRd(2'd3);
    eStart(); idle();
    swRd(2'd0); swWr(2'd2, 8'h77); swRd(2'd2);
    swWr(2'd3, 8'h02); swRd(2'd0); swRd(2'd2);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule